// File: doc/BRIEF.md
# Indirect-Window Interrupt Routing Register File

This block is the programmable state of an I/O interrupt router. Software reaches it through two word locations on a plain 32-bit memory-mapped bus. A write to the index location picks one internal register, and the data location then reads or writes that register. The internal registers are an identity word, a read-only capability word, and a table holding one 64-bit routing entry per interrupt pin. Software reaches each entry as two 32-bit halves. A third bus location takes end-of-interrupt (EOI) writes directly, and exists only in the newer variant.

The delivery engine next to the block reads every routing entry in parallel from a flat export bus. It reports two things back per pin: a request to set the entry's remote-IRR flag when it accepts a level interrupt, and a pending level that the block mirrors into the delivery-status bit. An accepted EOI goes out as a one-cycle strobe with its vector. In the same cycle it clears remote-IRR on every level-mode entry that holds that vector. Each pin counts the EOIs that clear its remote-IRR and raises a storm flag once the count reaches a limit, so the engine can pace re-delivery. Any software write to that entry resets the count.

Top module: `irq_route_regs`

## Requirements
- R1: After reset, the index register and the identity field are 0 and no EOI strobe or storm flag is set. Every routing entry equals 64'h0000_0000_0001_0000, so only the mask bit (bit 16) is 1.
- R2: A write to bus offset 0x00 loads bits [7:0] of the data into the index register. A read of offset 0x00 returns the index in bits [7:0] and zero elsewhere.
- R3: Bus reads return data on bus_rdata one cycle after the request. At offset 0x10, an index of 0x10+2k selects bits [31:0] of entry k and an index of 0x11+2k selects bits [63:32] of entry k, for k below N.
- R4: Index 0x01 reads as a capability word with VERSION in bits [7:0], N-1 in bits [23:16], and zero elsewhere. Writes to it have no effect.
- R5: Index 0x00 holds a 4-bit identity field. A write stores only data bits [27:24], and a read returns them in bits [27:24] with zero elsewhere.
- R6: On a table write, the written data replaces vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], trigger mode [15], mask [16] and destination [63:48]. Delivery status [12] and remote-IRR [14] keep their hardware values, and bits [47:17] stay 0.
- R7: After any table write that leaves trigger mode at 0 (edge), remote-IRR of that entry is 0.
- R8: A pulse on rirr_set[k] sets remote-IRR of entry k at the next edge only when its trigger mode is 1 (level). Delivery status of entry k equals dlv_pend[k] from the previous cycle.
- R9: A write to offset 0x40 yields eoi_valid for exactly one cycle, starting one cycle after the write, with eoi_vector equal to data bits [7:0]. This happens only when bus_be is 4'hF and VERSION is 0x20. A partial-byte write, or any write when VERSION is 0x11, gives no strobe and clears nothing.
- R10: An accepted EOI clears remote-IRR of every level-mode entry whose vector equals the EOI vector, at the edge where eoi_valid rises. Entries with another vector keep their remote-IRR.
- R11: Each accepted EOI that clears remote-IRR of entry k counts once. storm[k] is 1 while that count is at or above STORM_LIMIT. Any table write to entry k sets its count to 0.
- R12: At offset 0x10, an index from 0x02 to 0x0F, or at or above 0x10+2N, reads as 0. A write there changes no entry and no identity field.
- R13: rte_flat[64k+63:64k] carries entry k at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_be | input | 4 | Byte enables; only the EOI location looks at them |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| rirr_set | input | N | Per-pin request from the delivery engine to set remote-IRR |
| dlv_pend | input | N | Per-pin delivery pending level, mirrored into delivery status |
| rte_flat | output | 64*N | All routing entries, entry k at bits [64k+63:64k] |
| eoi_valid | output | 1 | One-cycle strobe for an accepted EOI |
| eoi_vector | output | 8 | Vector of the accepted EOI |
| storm | output | N | Per-pin flag: EOI count reached STORM_LIMIT |

## Verification
The table is swept across all 24 entries with data that differs per entry and covers every bit of both halves. Each read-back has to match the masked value computed in the bench. This exposes index mapping errors, swapped halves and bits that should be protected but are not. Remote-IRR and delivery status are set from the engine side and then overwritten from the bus with opposing values, which separates bits that hold their hardware value from bits that take bus data. The EOI path is tried three ways: a full write, a partial-byte write, and the same full write to an instance built with the older version code. This shows apart gating by byte enables, gating by version, and clearing by vector match. Index values in the reserved gap, just past the last entry and at the top of the 8-bit range tell a real zero read from aliasing onto a live entry.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Routing entry layout. The delivery engine decodes these positions.
    localparam int RTE_W     = 64;
    localparam int VEC_W     = 8;
    localparam int DS_BIT    = 12;
    localparam int RIRR_BIT  = 14;
    localparam int TRIG_BIT  = 15;
    localparam int MASK_BIT  = 16;

    typedef logic [RTE_W-1:0] rte_t;

    // Bits software may write: vector, delivery mode, destination mode,
    // polarity, trigger mode, mask and destination.
    localparam rte_t RTE_RW_MASK = 64'hFFFF_0000_0001_AFFF;
    localparam rte_t RTE_RESET   = rte_t'(1) << MASK_BIT;

    // Internal index values
    localparam logic [7:0] IDX_IDENT = 8'h00;
    localparam logic [7:0] IDX_CAPS  = 8'h01;
    localparam logic [7:0] IDX_TABLE = 8'h10;

    // Identity field placement
    localparam int IDENT_LSB = 24;
    localparam int IDENT_W   = 4;

    typedef struct packed {
        logic       is_ident;
        logic       is_caps;
        logic       is_table;
        logic       upper;
        logic [7:0] entry;
    } idx_dec_t;

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int N = 24
) (
    input  logic [7:0] idx,
    output idx_dec_t   dec
);
    logic [7:0] rel;

    always_comb begin
        rel          = idx - IDX_TABLE;
        dec          = '0;
        dec.is_ident = (idx == IDX_IDENT);
        dec.is_caps  = (idx == IDX_CAPS);
        dec.is_table = (idx >= IDX_TABLE) && (int'(rel[7:1]) < N);
        dec.upper    = rel[0];
        dec.entry    = {1'b0, rel[7:1]};
    end

endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
    import irq_route_pkg::*;
#(
    parameter int CNT_W       = 14,
    parameter int STORM_LIMIT = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    input  logic             eoi_fire,
    input  logic [VEC_W-1:0] eoi_vec,
    input  logic             rirr_set,
    input  logic             dlv_pend,
    output rte_t             rte,
    output logic             storm
);
    typedef struct packed {
        rte_t             rte;
        logic [CNT_W-1:0] cnt;
    } ent_st_t;

    ent_st_t st_d, st_q;
    rte_t    merged;
    logic    eoi_match;

    always_comb begin
        st_d   = st_q;
        merged = st_q.rte;
        if (wr_lo) merged[31:0]  = wdata;
        if (wr_hi) merged[63:32] = wdata;
        if (wr_lo || wr_hi) begin
            st_d.rte = (merged & RTE_RW_MASK) | (st_q.rte & ~RTE_RW_MASK);
            st_d.cnt = '0;
        end
        st_d.rte[DS_BIT] = dlv_pend;

        eoi_match = eoi_fire && st_q.rte[TRIG_BIT] && st_q.rte[RIRR_BIT]
                    && (st_q.rte[VEC_W-1:0] == eoi_vec);
        if (eoi_match) begin
            st_d.rte[RIRR_BIT] = 1'b0;
            if (st_d.cnt != '1) st_d.cnt = st_d.cnt + 1'b1;
        end
        if (rirr_set && st_d.rte[TRIG_BIT]) st_d.rte[RIRR_BIT] = 1'b1;
        if (!st_d.rte[TRIG_BIT])            st_d.rte[RIRR_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rte <= RTE_RESET;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rte   = st_q.rte;
    assign storm = (st_q.cnt >= CNT_W'(STORM_LIMIT));

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int              N           = 24,
    parameter logic [7:0]      VERSION     = 8'h20,
    parameter int              STORM_LIMIT = 10000,
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] SEL_OFF   = 'h00,
    parameter logic [ADDR_W-1:0] WIN_OFF   = 'h10,
    parameter logic [ADDR_W-1:0] EOI_OFF   = 'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N-1:0]      rirr_set,
    input  logic [N-1:0]      dlv_pend,
    output logic [N*64-1:0]   rte_flat,
    output logic              eoi_valid,
    output logic [7:0]        eoi_vector,
    output logic [N-1:0]      storm
);
    localparam bit          HAS_EOI  = (VERSION == 8'h20);
    localparam int          CNT_W    = $clog2(STORM_LIMIT + 1);
    localparam int          IDXS_W   = (N > 1) ? $clog2(N) : 1;
    localparam logic [31:0] CAPS_WORD = {8'h00, 8'(N - 1), 8'h00, VERSION};

    if (VERSION != 8'h11 && VERSION != 8'h20) begin : g_bad_version
        $error("irq_route_regs: VERSION must be 8'h11 or 8'h20");
    end

    typedef struct packed {
        logic [7:0]         idx;
        logic [IDENT_W-1:0] ident;
        logic [31:0]        rdata;
        logic               eoi_v;
        logic [7:0]         eoi_vec;
    } top_st_t;

    top_st_t  st_d, st_q;
    idx_dec_t dec;
    rte_t     rte_arr [N];
    logic     hit_sel, hit_win, hit_eoi, win_wr, eoi_fire;
    logic [N-1:0] wr_lo, wr_hi;
    rte_t     rd_rte;

    irq_route_decode #(.N(N)) u_decode (
        .idx (st_q.idx),
        .dec (dec)
    );

    assign hit_sel  = bus_valid && (bus_addr == SEL_OFF);
    assign hit_win  = bus_valid && (bus_addr == WIN_OFF);
    assign hit_eoi  = bus_valid && (bus_addr == EOI_OFF);
    assign win_wr   = hit_win && bus_write;
    assign eoi_fire = HAS_EOI && hit_eoi && bus_write && (bus_be == 4'hF);

    for (genvar k = 0; k < N; k++) begin : g_entry
        assign wr_lo[k] = win_wr && dec.is_table && !dec.upper && (dec.entry == 8'(k));
        assign wr_hi[k] = win_wr && dec.is_table &&  dec.upper && (dec.entry == 8'(k));

        irq_route_entry #(
            .CNT_W       (CNT_W),
            .STORM_LIMIT (STORM_LIMIT)
        ) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_lo[k]),
            .wr_hi    (wr_hi[k]),
            .wdata    (bus_wdata),
            .eoi_fire (eoi_fire),
            .eoi_vec  (bus_wdata[7:0]),
            .rirr_set (rirr_set[k]),
            .dlv_pend (dlv_pend[k]),
            .rte      (rte_arr[k]),
            .storm    (storm[k])
        );

        assign rte_flat[k*64 +: 64] = rte_arr[k];
    end

    assign rd_rte = rte_arr[dec.entry[IDXS_W-1:0]];

    always_comb begin
        st_d = st_q;

        if (hit_sel && bus_write) st_d.idx = bus_wdata[7:0];
        if (win_wr && dec.is_ident) st_d.ident = bus_wdata[IDENT_LSB +: IDENT_W];

        st_d.eoi_v = eoi_fire;
        if (eoi_fire) st_d.eoi_vec = bus_wdata[7:0];

        if (bus_valid && !bus_write) begin
            st_d.rdata = '0;
            if (hit_sel) begin
                st_d.rdata[7:0] = st_q.idx;
            end else if (hit_win) begin
                if (dec.is_ident) begin
                    st_d.rdata[IDENT_LSB +: IDENT_W] = st_q.ident;
                end else if (dec.is_caps) begin
                    st_d.rdata = CAPS_WORD;
                end else if (dec.is_table) begin
                    st_d.rdata = dec.upper ? rd_rte[63:32] : rd_rte[31:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign eoi_valid  = st_q.eoi_v;
    assign eoi_vector = st_q.eoi_vec;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int                N       = 24,
    parameter logic [7:0]        VERSION = 8'h20,
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] EOI_OFF = 'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [7:0]        eoi_wdata,
    input logic              eoi_valid,
    input logic [7:0]        eoi_vector,
    input logic [N*64-1:0]   rte_flat,
    input logic [N-1:0]      dlv_pend
);
    localparam logic [N*64-1:0] STATUS_FLAT = {N{64'h0000_0000_0000_5000}};

    // R6: without a bus write, software-visible bits of every entry hold
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write) |=> ((rte_flat & ~STATUS_FLAT) == $past(rte_flat & ~STATUS_FLAT)));

    // R9: a strobe is always preceded by a full-width write to the EOI offset
    p_eoi_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(bus_valid && bus_write && bus_addr == EOI_OFF && bus_be == 4'hF));

    // R9: strobe carries the vector written in the previous cycle
    p_eoi_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> (eoi_vector == $past(eoi_wdata)));

    if (VERSION != 8'h20) begin : g_old
        // R9: older variant never produces a strobe
        p_no_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n) !eoi_valid);
    end

    for (genvar k = 0; k < N; k++) begin : g_pin
        // R7: remote-IRR can only be held by a level-mode entry
        p_rirr_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rte_flat[k*64 + 14] |-> rte_flat[k*64 + 15]);

        // R8: delivery status follows the engine's pending level by one cycle
        p_ds_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (rte_flat[k*64 + 12] == $past(dlv_pend[k])));
    end

endmodule

bind irq_route_regs irq_route_chk #(
    .N       (N),
    .VERSION (VERSION),
    .ADDR_W  (ADDR_W),
    .EOI_OFF (EOI_OFF)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .eoi_wdata  (bus_wdata[7:0]),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .rte_flat   (rte_flat),
    .dlv_pend   (dlv_pend)
);

// File: tb/irq_route_regs_tb_top.sv
module irq_route_regs_tb_top;
    localparam int NP    = 24;
    localparam int LIMIT = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [3:0]        bus_be = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata, rdata_o;
    logic [NP-1:0]     rirr_set = '0;
    logic [NP-1:0]     dlv_pend = '0;
    logic [NP*64-1:0]  rte_flat, rte_o;
    logic              eoi_valid, eoi_valid_o;
    logic [7:0]        eoi_vector, eoi_vector_o;
    logic [NP-1:0]     storm, storm_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_route_regs #(.N(NP), .VERSION(8'h20), .STORM_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rirr_set(rirr_set), .dlv_pend(dlv_pend), .rte_flat(rte_flat),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .storm(storm));

    irq_route_regs #(.N(NP), .VERSION(8'h11), .STORM_LIMIT(LIMIT)) dut_old_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata_o),
        .rirr_set(rirr_set), .dlv_pend(dlv_pend), .rte_flat(rte_o),
        .eoi_valid(eoi_valid_o), .eoi_vector(eoi_vector_o), .storm(storm_o));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ent(input int k);
        return rte_flat[k*64 +: 64];
    endfunction

    function automatic logic [63:0] ent_old(input int k);
        return rte_o[k*64 +: 64];
    endfunction

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic wr_half(input int k, input bit hi, input logic [31:0] d);
        bus_wr(8'h00, 32'(8'h10 + 2*k + hi), 4'hF);
        bus_wr(8'h10, d, 4'hF);
    endtask

    task automatic rd_half(input int k, input bit hi, output logic [31:0] d);
        bus_wr(8'h00, 32'(8'h10 + 2*k + hi), 4'hF);
        bus_rd(8'h10, d);
    endtask

    task automatic pulse_rirr(input logic [NP-1:0] m);
        @(negedge clk); rirr_set = m;
        @(negedge clk); rirr_set = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] lo_w, hi_w;
        logic [31:0] exp_lo [NP];
        logic [31:0] exp_hi [NP];
        logic [NP*64-1:0] snap;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int k = 0; k < NP; k++) check("R1 entry reset", ent(k), 64'h0000_0000_0001_0000);
        check("R1 strobe", {63'b0, eoi_valid}, 64'd0);
        check("R1 storm", {40'b0, storm}, 64'd0);
        bus_rd(8'h00, d);
        check("R1 index reset", {32'b0, d}, 64'd0);
        bus_rd(8'h10, d);
        check("R1 identity reset", {32'b0, d}, 64'd0);

        // R2: index register readback, low byte only
        bus_wr(8'h00, 32'h1234_56A5, 4'hF);
        bus_rd(8'h00, d);
        check("R2 index readback", {32'b0, d}, 64'h0000_00A5);

        // R4: capability word for both variants, writes ignored
        bus_wr(8'h00, 32'h01, 4'hF);
        bus_wr(8'h10, 32'hFFFF_FFFF, 4'hF);
        bus_rd(8'h10, d);
        check("R4 caps new", {32'b0, d}, {32'b0, 8'h00, 8'(NP - 1), 8'h00, 8'h20});
        check("R4 caps old", {32'b0, rdata_o}, {32'b0, 8'h00, 8'(NP - 1), 8'h00, 8'h11});

        // R5: identity field only takes bits [27:24]
        bus_wr(8'h00, 32'h00, 4'hF);
        bus_wr(8'h10, 32'hFFFF_FFFF, 4'hF);
        bus_rd(8'h10, d);
        check("R5 identity all ones", {32'b0, d}, 64'h0F00_0000);
        bus_wr(8'h10, 32'hF5FF_FFFF, 4'hF);
        bus_rd(8'h10, d);
        check("R5 identity pattern", {32'b0, d}, 64'h0500_0000);

        // R3 R6 R13: sweep of every entry with per-entry data
        for (int k = 0; k < NP; k++) begin
            lo_w = 32'h5A3C_F0F0 ^ (k * 32'h0001_9E37);
            hi_w = 32'hC3A5_1E2D + k * 32'h0713_0000;
            wr_half(k, 1'b0, lo_w);
            wr_half(k, 1'b1, hi_w);
            exp_lo[k] = lo_w & 32'h0001_AFFF;
            exp_hi[k] = hi_w & 32'hFFFF_0000;
        end
        for (int k = 0; k < NP; k++) begin
            rd_half(k, 1'b0, d);
            check("R3 R6 lower half", {32'b0, d}, {32'b0, exp_lo[k]});
            rd_half(k, 1'b1, d);
            check("R3 R6 upper half", {32'b0, d}, {32'b0, exp_hi[k]});
            check("R13 export", ent(k), {exp_hi[k], exp_lo[k]});
        end

        // Known state: all level, unmasked, vector 0x40+k
        for (int k = 0; k < NP; k++) wr_half(k, 1'b0, 32'h0000_8040 + k);
        wr_half(4, 1'b0, 32'h0000_0043);        // entry 4 edge, vector 0x43
        wr_half(3, 1'b0, 32'h0000_8043);        // entry 3 level, vector 0x43

        // R8: remote-IRR set only for level mode
        pulse_rirr(NP'(1) << 3 | NP'(1) << 4 | NP'(1) << 6);
        check("R8 rirr level entry", {63'b0, ent(3)[14]}, 64'd1);
        check("R8 rirr edge entry", {63'b0, ent(4)[14]}, 64'd0);
        @(negedge clk); dlv_pend[5] = 1'b1;
        @(negedge clk);
        check("R8 delivery status", {63'b0, ent(5)[12]}, 64'd1);

        // R6: status bits keep hardware values against bus data
        wr_half(5, 1'b0, 32'h0000_8045);
        check("R6 delivery status kept", ent(5)[31:0], 64'h0000_9045);
        wr_half(3, 1'b0, 32'h0000_8043);
        check("R6 rirr kept", {63'b0, ent(3)[14]}, 64'd1);
        wr_half(7, 1'b0, 32'h0000_D047);
        check("R6 status not writable", ent(7)[31:0], 64'h0000_8047);
        @(negedge clk); dlv_pend[5] = 1'b0;

        // R7: switching to edge clears remote-IRR
        wr_half(3, 1'b0, 32'h0000_0043);
        check("R7 edge clears rirr", {63'b0, ent(3)[14]}, 64'd0);
        wr_half(3, 1'b0, 32'h0000_8043);
        pulse_rirr(NP'(1) << 3);
        check("R7 rirr again", {63'b0, ent(3)[14]}, 64'd1);

        // R9: partial EOI ignored
        bus_wr(8'h40, 32'h0000_0043, 4'h7);
        check("R9 partial no strobe", {63'b0, eoi_valid}, 64'd0);
        check("R9 partial no clear", {63'b0, ent(3)[14]}, 64'd1);

        // R9 R10: full EOI
        bus_wr(8'h40, 32'hABCD_0043, 4'hF);
        check("R9 strobe", {63'b0, eoi_valid}, 64'd1);
        check("R9 vector", {56'b0, eoi_vector}, 64'h43);
        check("R9 old variant no strobe", {63'b0, eoi_valid_o}, 64'd0);
        check("R10 match cleared", {63'b0, ent(3)[14]}, 64'd0);
        check("R10 other vector kept", {63'b0, ent(6)[14]}, 64'd1);
        check("R9 old variant no clear", {63'b0, ent_old(3)[14]}, 64'd1);
        @(negedge clk);
        check("R9 strobe one cycle", {63'b0, eoi_valid}, 64'd0);

        // R11: storm counting and reset by table write
        wr_half(3, 1'b0, 32'h0000_8043);
        for (int i = 0; i < LIMIT; i++) begin
            check("R11 below limit", {63'b0, storm[3]}, 64'd0);
            pulse_rirr(NP'(1) << 3);
            bus_wr(8'h40, 32'h0000_0043, 4'hF);
        end
        check("R11 storm at limit", {63'b0, storm[3]}, 64'd1);
        check("R11 other pin quiet", {63'b0, storm[6]}, 64'd0);
        wr_half(3, 1'b1, ent(3)[63:32]);
        check("R11 write resets count", {63'b0, storm[3]}, 64'd0);

        // R12: undefined indexes read zero and ignore writes
        snap = rte_flat;
        bus_wr(8'h00, 32'h0000_0005, 4'hF);
        bus_wr(8'h10, 32'hFFFF_FFFF, 4'hF);
        bus_rd(8'h10, d);
        check("R12 gap reads zero", {32'b0, d}, 64'd0);
        bus_wr(8'h00, 32'(8'h10 + 2*NP), 4'hF);
        bus_wr(8'h10, 32'hFFFF_FFFF, 4'hF);
        bus_rd(8'h10, d);
        check("R12 past last reads zero", {32'b0, d}, 64'd0);
        bus_wr(8'h00, 32'h0000_00FF, 4'hF);
        bus_wr(8'h10, 32'h0000_0000, 4'hF);
        bus_rd(8'h10, d);
        check("R12 top index reads zero", {32'b0, d}, 64'd0);
        check("R12 table untouched", {63'b0, rte_flat == snap}, 64'd1);
        bus_wr(8'h00, 32'h00, 4'hF);
        bus_rd(8'h10, d);
        check("R12 identity untouched", {32'b0, d}, 64'h0500_0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule